// File: doc/BRIEF.md
# Pipelined Four-Value Sorter

This block puts four unsigned values into descending order. A caller presents the four values with a valid strobe. The values pass through a fixed network of five compare-exchange cells arranged in three layers, with a register after each layer. The sorted set appears on the outputs a fixed number of cycles later, together with a matching valid flag.

The block has no flow control and never stalls, so a new set of values can enter on every clock cycle. Each compare-exchange cell swaps its pair only when the lower-indexed value is strictly smaller. As a result, equal values pass through untouched and never corrupt the result.

The first layer pairs positions 0/2 and 1/3. The second layer pairs 0/1 and 2/3. The last layer pairs 1/2.

Top module: `sort4_pipe`

## Requirements
- R1: When `out_vld` is high, the outputs are in descending unsigned order: `out_d0` >= `out_d1` >= `out_d2` >= `out_d3`. Output 0 holds the largest value and output 3 the smallest.
- R2: The four outputs are a permutation of the four inputs captured with the same strobe. Each input value appears exactly once.
- R3: A set captured at a rising edge where `in_vld` is high appears on the outputs, with `out_vld` high, right after the third rising edge counted from that capture edge.
- R4: A new set can be accepted on every cycle. Back-to-back sets come out on consecutive cycles, in the order they went in.
- R5: A cycle with `in_vld` low yields a cycle with `out_vld` low three edges later. The data inputs in such a cycle have no effect on any flagged result.
- R6: A synchronous reset (`rst` high at a rising edge) clears all valid stages, so `out_vld` is low after that edge.
- R7: Comparison is unsigned. For example, 8'h80 and 8'hFF rank above 8'h7F and 8'h00.
- R8: Sets with repeated values, including all-equal sets, come out correctly ordered, and each repeat keeps its multiplicity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input set valid; captures the set |
| in_d0 | input | W | Input value, position 0 |
| in_d1 | input | W | Input value, position 1 |
| in_d2 | input | W | Input value, position 2 |
| in_d3 | input | W | Input value, position 3 |
| out_vld | output | 1 | Sorted set valid |
| out_d0 | output | W | Largest value |
| out_d1 | output | W | Second largest value |
| out_d2 | output | W | Third largest value |
| out_d3 | output | W | Smallest value |

## Verification
The assertions that look back three cycles take for granted two things about the inputs. First, the data inputs carry defined values in every cycle in which `in_vld` is high. Second, reset is held for at least one edge before any traffic. The stimulus holds reset for several cycles from time zero. It also drives every data input to a defined value on every cycle, including the cycles without a strobe, and changes inputs only on the falling edge. The streams mix full-rate bursts, gaps, repeated values and values on both sides of the sign boundary, so that the equality and unsigned paths of each compare-exchange cell are exercised.

// File: rtl/sort4_pipe.sv
module sort4_pipe #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] in_d0,
  input  logic [W-1:0] in_d1,
  input  logic [W-1:0] in_d2,
  input  logic [W-1:0] in_d3,
  output logic         out_vld,
  output logic [W-1:0] out_d0,
  output logic [W-1:0] out_d1,
  output logic [W-1:0] out_d2,
  output logic [W-1:0] out_d3
);

  localparam int SW = W + 2;

  logic [2:0] vpipe;

  // layer 1: pairs (0,2) and (1,3)
  logic [W-1:0] l1_0, l1_1, l1_2, l1_3;
  logic [W-1:0] r1_0, r1_1, r1_2, r1_3;
  logic sw02, sw13;
  assign sw02 = in_d0 < in_d2;
  assign sw13 = in_d1 < in_d3;
  assign l1_0 = sw02 ? in_d2 : in_d0;
  assign l1_2 = sw02 ? in_d0 : in_d2;
  assign l1_1 = sw13 ? in_d3 : in_d1;
  assign l1_3 = sw13 ? in_d1 : in_d3;

  // layer 2: pairs (0,1) and (2,3)
  logic [W-1:0] l2_0, l2_1, l2_2, l2_3;
  logic [W-1:0] r2_0, r2_1, r2_2, r2_3;
  logic sw01, sw23;
  assign sw01 = r1_0 < r1_1;
  assign sw23 = r1_2 < r1_3;
  assign l2_0 = sw01 ? r1_1 : r1_0;
  assign l2_1 = sw01 ? r1_0 : r1_1;
  assign l2_2 = sw23 ? r1_3 : r1_2;
  assign l2_3 = sw23 ? r1_2 : r1_3;

  // layer 3: pair (1,2)
  logic [W-1:0] l3_1, l3_2;
  logic sw12;
  assign sw12 = r2_1 < r2_2;
  assign l3_1 = sw12 ? r2_2 : r2_1;
  assign l3_2 = sw12 ? r2_1 : r2_2;

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[1:0], in_vld};
  end

  always_ff @(posedge clk) begin
    r1_0 <= l1_0; r1_1 <= l1_1; r1_2 <= l1_2; r1_3 <= l1_3;
    r2_0 <= l2_0; r2_1 <= l2_1; r2_2 <= l2_2; r2_3 <= l2_3;
    out_d0 <= r2_0;
    out_d1 <= l3_1;
    out_d2 <= l3_2;
    out_d3 <= r2_3;
  end

  assign out_vld = vpipe[2];

  // checking aids: cycles since reset, and sums of each side
  logic [1:0]    age;
  logic [SW-1:0] in_sum, out_sum;
  always_ff @(posedge clk) begin
    if (rst)            age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign in_sum  = SW'(in_d0) + SW'(in_d1) + SW'(in_d2) + SW'(in_d3);
  assign out_sum = SW'(out_d0) + SW'(out_d1) + SW'(out_d2) + SW'(out_d3);

  assert_desc_order_R1: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_d0 >= out_d1 && out_d1 >= out_d2 && out_d2 >= out_d3));

  assert_sum_kept_R2: assert property (@(posedge clk) disable iff (rst)
    (out_vld && age == 2'd3) |-> out_sum == $past(in_sum, 3));

  assert_valid_delay_R3: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> out_vld == $past(in_vld, 3));

  assert_reset_clears_R6: assert property (@(posedge clk)
    $past(rst) |-> !out_vld);

endmodule

// File: tb/sim_sort4_pipe.sv
module sim_sort4_pipe;
  localparam int W = 8;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic [W-1:0] in_d0 = '0, in_d1 = '0, in_d2 = '0, in_d3 = '0;
  logic out_vld;
  logic [W-1:0] out_d0, out_d1, out_d2, out_d3;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  string cur_req = "R6";

  always #(PERIOD/2) clk = ~clk;

  sort4_pipe #(.W(W)) u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .in_d0(in_d0), .in_d1(in_d1), .in_d2(in_d2), .in_d3(in_d3),
    .out_vld(out_vld),
    .out_d0(out_d0), .out_d1(out_d1), .out_d2(out_d2), .out_d3(out_d3)
  );

  // reference model: queue-like history of expected results
  bit m_v [3];
  int m_d [3][4];

  function automatic void ref_sort(input int a, b, c, d, output int r [4]);
    int t [4];
    t[0] = a; t[1] = b; t[2] = c; t[3] = d;
    for (int i = 0; i < 4; i++)
      for (int j = i + 1; j < 4; j++)
        if (t[j] > t[i]) begin int x; x = t[i]; t[i] = t[j]; t[j] = x; end
    r = t;
  endfunction

  always @(posedge clk) begin
    int s [4];
    ref_sort(int'(in_d0), int'(in_d1), int'(in_d2), int'(in_d3), s);
    if (rst) begin
      for (int k = 0; k < 3; k++) m_v[k] = 1'b0;
    end else begin
      m_v[2] = m_v[1]; m_d[2] = m_d[1];
      m_v[1] = m_v[0]; m_d[1] = m_d[0];
      m_v[0] = in_vld; m_d[0] = s;
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(cur_req, int'(out_vld), int'(m_v[2]), "out_vld");
      if (m_v[2]) begin
        check(cur_req, int'(out_d0), m_d[2][0], "out_d0");
        check(cur_req, int'(out_d1), m_d[2][1], "out_d1");
        check(cur_req, int'(out_d2), m_d[2][2], "out_d2");
        check(cur_req, int'(out_d3), m_d[2][3], "out_d3");
      end
    end
  end

  task automatic put(input bit v, input int a, b, c, d);
    @(negedge clk);
    in_vld = v;
    in_d0 = W'(a); in_d1 = W'(b); in_d2 = W'(c); in_d3 = W'(d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b0, 8'h5A, 8'hA5, 8'hFF, 8'h00);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R6: reset clears valid, even with in_vld high beforehand
    in_vld = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R6", int'(out_vld), 0, "out_vld during reset");
    in_vld = 1'b0;
    rst = 1'b0;
    idle(4);

    // R3: single set, latency of three edges
    cur_req = "R3";
    put(1'b1, 3, 9, 1, 7);
    put(1'b0, 0, 0, 0, 0);
    @(posedge clk); #1;
    check("R3", int'(out_vld), 0, "out_vld after edge 2");
    @(posedge clk); #1;
    check("R3", int'(out_vld), 1, "out_vld after edge 3");
    check("R3", int'(out_d0), 9, "out_d0");
    check("R3", int'(out_d3), 1, "out_d3");
    idle(4);

    // R1 and R2: all 24 orderings of distinct values
    cur_req = "R1_R2";
    for (int p = 0; p < 24; p++) begin
      int v [4];
      int pool [4];
      int f;
      pool[0] = 10; pool[1] = 20; pool[2] = 30; pool[3] = 40;
      f = p;
      for (int k = 0; k < 4; k++) begin
        int idx;
        idx = f % (4 - k);
        f = f / (4 - k);
        v[k] = pool[idx];
        for (int m = idx; m < 3 - k; m++) pool[m] = pool[m + 1];
      end
      put(1'b1, v[0], v[1], v[2], v[3]);
    end

    // R4: full-rate pseudo-random stream
    cur_req = "R4";
    for (int i = 0; i < 200; i++)
      put(1'b1, (i * 37 + 11) % 256, (i * 91 + 5) % 256, (i * 13 + 200) % 256, (i * 53 + 77) % 256);

    // R5: gaps between sets, junk data on gap cycles
    cur_req = "R5";
    for (int i = 0; i < 60; i++)
      put((i % 3) == 0, (i * 71) % 256, (i * 29) % 256, (i * 113) % 256, (i * 7) % 256);
    idle(4);

    // R7: unsigned ranking around the top bit
    cur_req = "R7";
    put(1'b1, 8'h7F, 8'h80, 8'h00, 8'hFF);
    put(1'b1, 8'h80, 8'h7F, 8'h81, 8'h01);
    put(1'b1, 8'hFE, 8'h02, 8'h7F, 8'h80);
    idle(4);

    // R8: ties and repeated values
    cur_req = "R8";
    put(1'b1, 5, 5, 5, 5);
    put(1'b1, 9, 9, 2, 2);
    put(1'b1, 2, 9, 2, 9);
    put(1'b1, 7, 3, 7, 3);
    put(1'b1, 255, 0, 0, 255);
    put(1'b1, 4, 4, 4, 1);
    put(1'b1, 1, 8, 8, 8);
    for (int i = 0; i < 40; i++)
      put(1'b1, i % 3, (i / 3) % 3, (i / 9) % 3, 2 - (i % 3));
    idle(5);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule